// File: doc/BRIEF.md
# Unlock-Cycle Flash Bank Sequencer

This block erases or reprograms one bank of a byte-wide flash device. The device accepts a command only after a fixed preamble of unlock writes. It reports that an internal operation has finished by no longer toggling a status bit on successive reads. The host picks a bank and pulses either the erase start or the program start. For programming, the sequencer fetches each source byte from a host buffer through a combinational read port addressed by `buf_addr`. It then runs the whole operation without further help, raises `done` for one cycle, and leaves two sticky error flags for the host to read.

Each operation has four phases. First come the command writes, which are unlock writes at bank-relative offsets 0x555 and 0x2AA followed by the operation code. Next the block polls by reading the bank base twice in a row. The third phase is a device-reset write of 0xF0 to the bank base. Last comes a read-back pass over the whole bank. A programming run repeats the command and poll phases once per byte. Every flash write is followed by a programmable quiet gap, which by default is 200 cycles (1 µs at 200 MHz).

The controller states and their transitions are:
- IDLE goes to CMD on a start.
- CMD (one write) always goes to GAP.
- GAP goes back to CMD for the next step, or to POLL_A after the last step.
- POLL_A goes to POLL_B.
- POLL_B goes to CMD for the next byte when the pair matched, to RST when finished or when the attempt limit is reached, and otherwise back to POLL_A.
- RST goes to RST_GAP, and RST_GAP goes to VERIFY.
- VERIFY goes to FINISH on a mismatch or after the last byte.
- FINISH goes to IDLE.

Top module: `toggle_flash_seq`

## Requirements
- R1: An erase issues six writes, each address being the bank base plus an offset, in this order: (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x000,0x30). The bank base is the bank number times BANK_BYTES. No write goes outside the selected bank.
- R2: Programming issues, for every byte offset from 0 to BANK_BYTES-1 in ascending order, the writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), and then the buffer byte at its own offset.
- R3: Between any two write strobes there are at least GAP_CYC cycles without a write.
- R4: After the last command write of a step, the block reads the bank base in pairs of back-to-back reads. It moves on only when the two values of a pair are equal, and it never asserts the read and write strobes together.
- R5: After POLL_LIMIT unequal pairs, `timeout_err` is set and polling stops. During programming, no further bytes are written after that.
- R6: Every operation, whether it succeeded or failed, ends its writes with 0xF0 at the bank base. A GAP_CYC quiet gap follows before the first read-back.
- R7: The read-back expects 0xFF at every offset after an erase, or the buffer byte after programming. The first mismatch sets `verify_err` and ends the pass.
- R8: Both error flags hold their value while idle and are cleared by an accepted start. A start is accepted only when idle, and erase wins when both start inputs are high. Start inputs seen while busy have no effect.
- R9: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high. `done` is a single-cycle pulse. No flash strobe is asserted while `busy` is low.
- R10: After reset, `busy`, `done`, both error flags and both flash strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_erase | input | 1 | Start an erase of the selected bank (sampled when idle) |
| start_prog | input | 1 | Start programming the selected bank (sampled when idle) |
| bank_sel | input | BANK_W | Bank number, latched at start |
| buf_addr | output | OFS_W | Offset of the source byte wanted from the host buffer |
| buf_data | input | 8 | Source byte at `buf_addr`, valid in the same cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout_err | output | 1 | Sticky: polling attempt limit reached |
| verify_err | output | 1 | Sticky: read-back mismatch |
| fl_addr | output | BANK_W+OFS_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid in the cycle `fl_re` is high |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |

## Verification
The bench drives a behavioural flash with a small bank (2048 bytes). The model decodes the unlock preamble, counts protocol errors, toggles its status bit for a set number of reads, and can stall or drop a program. A design that polls a single read, or that advances while the device is still busy, is caught in two ways: the model flags a command written during a busy period, and the exact number of reads in an erase run comes out wrong. A stalled device exposes an off-by-one in the attempt limit, through the exact read count. The same stall also exposes a sequencer that keeps programming after a timeout, through the number of bytes written and through the blank byte that follows the stalled one. A dropped byte must be reported by the read-back without a timeout. A start pulse injected mid-erase for the other bank exposes a sequencer that re-latches its bank or operation.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_GAP,
        S_POLL_A,
        S_POLL_B,
        S_RST,
        S_RST_GAP,
        S_VERIFY,
        S_FINISH
    } fsq_state_e;

    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_PROG  = 1'b1
    } fsq_op_e;

    localparam logic [7:0] K_UNLOCK_A  = 8'hAA;
    localparam logic [7:0] K_UNLOCK_B  = 8'h55;
    localparam logic [7:0] K_ERASE_ARM = 8'h80;
    localparam logic [7:0] K_ERASE_GO  = 8'h30;
    localparam logic [7:0] K_PROG_ARM  = 8'hA0;
    localparam logic [7:0] K_DEV_RESET = 8'hF0;
    localparam logic [7:0] K_BLANK     = 8'hFF;

endpackage

// File: rtl/fsq_cmd_table.sv
module fsq_cmd_table
    import fsq_pkg::*;
#(
    parameter int OFS_W = 13
) (
    input  fsq_op_e          op,
    input  logic [2:0]       step,
    input  logic [OFS_W-1:0] ofs,
    input  logic [7:0]       data,
    output logic [OFS_W-1:0] cmd_ofs,
    output logic [7:0]       cmd_data,
    output logic             last
);
    localparam logic [OFS_W-1:0] ADDR_HI = OFS_W'(12'h555);
    localparam logic [OFS_W-1:0] ADDR_LO = OFS_W'(12'h2AA);

    always_comb begin
        cmd_ofs  = '0;
        cmd_data = K_UNLOCK_A;
        last     = 1'b0;
        if (op == OP_ERASE) begin
            case (step)
                3'd0:    begin cmd_ofs = ADDR_HI; cmd_data = K_UNLOCK_A;  end
                3'd1:    begin cmd_ofs = ADDR_LO; cmd_data = K_UNLOCK_B;  end
                3'd2:    begin cmd_ofs = ADDR_HI; cmd_data = K_ERASE_ARM; end
                3'd3:    begin cmd_ofs = ADDR_HI; cmd_data = K_UNLOCK_A;  end
                3'd4:    begin cmd_ofs = ADDR_LO; cmd_data = K_UNLOCK_B;  end
                default: begin cmd_ofs = '0; cmd_data = K_ERASE_GO; last = 1'b1; end
            endcase
        end else begin
            case (step)
                3'd0:    begin cmd_ofs = ADDR_HI; cmd_data = K_UNLOCK_A; end
                3'd1:    begin cmd_ofs = ADDR_LO; cmd_data = K_UNLOCK_B; end
                3'd2:    begin cmd_ofs = ADDR_HI; cmd_data = K_PROG_ARM; end
                default: begin cmd_ofs = ofs; cmd_data = data; last = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/fsq_gap_timer.sv
module fsq_gap_timer #(
    parameter int GAP_CYC = 200,
    localparam int DW = $clog2(GAP_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= DW'(GAP_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fsq_poll_count.sv
module fsq_poll_count #(
    parameter int POLL_LIMIT = 1000000,
    localparam int PW = $clog2(POLL_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == PW'(POLL_LIMIT - 1));
endmodule

// File: rtl/toggle_flash_seq.sv
module toggle_flash_seq
    import fsq_pkg::*;
#(
    parameter int BANK_BYTES = 8192,
    parameter int BANK_W     = 1,
    parameter int GAP_CYC    = 200,
    parameter int POLL_LIMIT = 1000000,
    localparam int OFS_W     = $clog2(BANK_BYTES),
    localparam int FA_W      = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_erase,
    input  logic              start_prog,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [OFS_W-1:0]  buf_addr,
    input  logic [7:0]        buf_data,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic              verify_err,
    output logic [FA_W-1:0]   fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              fl_we,
    output logic              fl_re
);
    fsq_state_e        state_q, state_d;
    fsq_op_e           op_q;
    logic [BANK_W-1:0] bank_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [2:0]        step_q;
    logic [7:0]        first_q;
    logic              tmo_q, vfy_q;

    logic [OFS_W-1:0]  cmd_ofs;
    logic [7:0]        cmd_data;
    logic              cmd_last;
    logic              gap_load, gap_done;
    logic              poll_clr, poll_inc, poll_last;
    logic              start_any, settled, ofs_last, vfy_bad;
    logic [7:0]        vfy_exp;

    fsq_cmd_table #(.OFS_W(OFS_W)) u_cmd (
        .op       (op_q),
        .step     (step_q),
        .ofs      (ofs_q),
        .data     (buf_data),
        .cmd_ofs  (cmd_ofs),
        .cmd_data (cmd_data),
        .last     (cmd_last)
    );

    fsq_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_done)
    );

    fsq_poll_count #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .inc      (poll_inc),
        .at_limit (poll_last)
    );

    assign start_any = start_erase | start_prog;
    assign settled   = ((first_q ^ fl_rdata) == 8'h00);
    assign ofs_last  = (ofs_q == {OFS_W{1'b1}});
    assign vfy_exp   = (op_q == OP_ERASE) ? K_BLANK : buf_data;
    assign vfy_bad   = (fl_rdata != vfy_exp);
    assign gap_load  = (state_q == S_CMD) || (state_q == S_RST);
    assign poll_clr  = (state_q == S_CMD);
    assign poll_inc  = (state_q == S_POLL_B) && !settled;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_any) state_d = S_CMD;
            S_CMD:     state_d = S_GAP;
            S_GAP:     if (gap_done) state_d = cmd_last ? S_POLL_A : S_CMD;
            S_POLL_A:  state_d = S_POLL_B;
            S_POLL_B: begin
                if (settled) begin
                    state_d = (op_q == OP_PROG && !ofs_last) ? S_CMD : S_RST;
                end else begin
                    state_d = poll_last ? S_RST : S_POLL_A;
                end
            end
            S_RST:     state_d = S_RST_GAP;
            S_RST_GAP: if (gap_done) state_d = S_VERIFY;
            S_VERIFY:  if (vfy_bad || ofs_last) state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_ERASE;
            bank_q  <= '0;
            ofs_q   <= '0;
            step_q  <= '0;
            first_q <= '0;
            tmo_q   <= 1'b0;
            vfy_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (start_any) begin
                        op_q   <= start_erase ? OP_ERASE : OP_PROG;
                        bank_q <= bank_sel;
                        ofs_q  <= '0;
                        step_q <= '0;
                        tmo_q  <= 1'b0;
                        vfy_q  <= 1'b0;
                    end
                end
                S_GAP: begin
                    if (gap_done && !cmd_last) step_q <= step_q + 3'd1;
                end
                S_POLL_A: first_q <= fl_rdata;
                S_POLL_B: begin
                    if (settled) begin
                        if (op_q == OP_PROG && !ofs_last) begin
                            ofs_q  <= ofs_q + 1'b1;
                            step_q <= '0;
                        end
                    end else if (poll_last) begin
                        tmo_q <= 1'b1;
                    end
                end
                S_RST_GAP: begin
                    if (gap_done) ofs_q <= '0;
                end
                S_VERIFY: begin
                    if (vfy_bad) vfy_q <= 1'b1;
                    else if (!ofs_last) ofs_q <= ofs_q + 1'b1;
                end
                S_CMD, S_RST, S_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != S_IDLE);
        done        = (state_q == S_FINISH);
        timeout_err = tmo_q;
        verify_err  = vfy_q;
        buf_addr    = ofs_q;
        fl_we       = 1'b0;
        fl_re       = 1'b0;
        fl_wdata    = K_DEV_RESET;
        fl_addr     = {bank_q, {OFS_W{1'b0}}};
        unique case (state_q)
            S_CMD: begin
                fl_we    = 1'b1;
                fl_addr  = {bank_q, cmd_ofs};
                fl_wdata = cmd_data;
            end
            S_POLL_A, S_POLL_B: fl_re = 1'b1;
            S_RST:    fl_we = 1'b1;
            S_VERIFY: begin
                fl_re   = 1'b1;
                fl_addr = {bank_q, ofs_q};
            end
            S_IDLE, S_GAP, S_RST_GAP, S_FINISH: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
    parameter int GAP_CYC = 200,
    localparam int SW = $clog2(GAP_CYC + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic start_erase,
    input logic start_prog,
    input logic busy,
    input logic done,
    input logic timeout_err,
    input logic verify_err,
    input logic fl_we,
    input logic fl_re
);
    logic [SW-1:0] since_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_we <= SW'(GAP_CYC);
        end else if (fl_we) begin
            since_we <= '0;
        end else if (since_we < SW'(GAP_CYC)) begin
            since_we <= since_we + 1'b1;
        end
    end

    a_r3_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> (since_we >= SW'(GAP_CYC)));

    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_we && !fl_re));

    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (start_erase || start_prog)) |=> (busy && !timeout_err && !verify_err));

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start_erase || start_prog)) |=> ($stable(timeout_err) && $stable(verify_err)));

    a_r5_timeout_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> busy);
endmodule

bind toggle_flash_seq fsq_checker #(.GAP_CYC(GAP_CYC)) u_fsq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_erase (start_erase),
    .start_prog  (start_prog),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .verify_err  (verify_err),
    .fl_we       (fl_we),
    .fl_re       (fl_re)
);

// File: tb/toggle_flash_seq_bench.sv
module toggle_flash_seq_bench;
    localparam int BB   = 2048;
    localparam int BW   = 1;
    localparam int GAP  = 2;
    localparam int PL   = 6;
    localparam int OW   = 11;
    localparam int FW   = 12;
    localparam int WDOG = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_erase = 1'b0;
    logic          start_prog = 1'b0;
    logic [BW-1:0] bank_sel = '0;
    logic [OW-1:0] buf_addr;
    logic [7:0]    buf_data;
    logic          busy, done, timeout_err, verify_err;
    logic [FW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;
    logic          fl_we, fl_re;

    int checks = 0;
    int errors = 0;
    int pmul = 7;
    int padd = 3;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] patt(int a, int m, int p);
        return 8'((a * m + p) ^ (a >> 8));
    endfunction

    function automatic logic [7:0] fillv(int i, int s);
        return 8'((i * 13 + s) ^ (i >> 3));
    endfunction

    assign buf_data = patt(int'(buf_addr), pmul, padd);

    toggle_flash_seq #(
        .BANK_BYTES (BB),
        .BANK_W     (BW),
        .GAP_CYC    (GAP),
        .POLL_LIMIT (PL)
    ) u_toggle_flash_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_erase (start_erase),
        .start_prog  (start_prog),
        .bank_sel    (bank_sel),
        .buf_addr    (buf_addr),
        .buf_data    (buf_data),
        .busy        (busy),
        .done        (done),
        .timeout_err (timeout_err),
        .verify_err  (verify_err),
        .fl_addr     (fl_addr),
        .fl_wdata    (fl_wdata),
        .fl_rdata    (fl_rdata),
        .fl_we       (fl_we),
        .fl_re       (fl_re)
    );

    // ---------------- behavioural flash ----------------
    logic [7:0] mem [0:2*BB-1];
    int   busy_left = 0;
    logic stuck = 1'b0;
    logic tog = 1'b0;
    int   mst = 0;
    int   n_wr = 0, n_rd = 0, n_erase = 0, n_prog = 0, n_rst = 0;
    int   seq_err = 0, gap_viol = 0, early_err = 0, bank_err = 0;
    int   cyc = 0, last_we = -1000;
    int   m_ofs, m_bk;
    logic [7:0]    last_wd = 8'h00;
    logic [FW-1:0] last_wa = '0;
    int   exp_bank = 0;
    int   stick_prog_ofs = -1;
    int   drop_ofs = -1;
    bit   stick_erase = 1'b0;
    bit   fill_req = 1'b0;
    int   fill_seed = 0;

    assign fl_rdata = (busy_left > 0 || stuck) ? {1'b0, tog, 6'b0} : mem[fl_addr];

    always @(posedge clk) begin
        cyc++;
        if (fill_req) begin
            for (int i = 0; i < 2 * BB; i++) mem[i] <= fillv(i, fill_seed);
        end
        if (fl_re) begin
            n_rd++;
            if (stuck) begin
                tog <= ~tog;
            end else if (busy_left > 0) begin
                tog <= ~tog;
                busy_left <= busy_left - 1;
            end
        end
        if (fl_we) begin
            m_ofs = int'(fl_addr[OW-1:0]);
            m_bk  = int'(fl_addr[FW-1]);
            n_wr++;
            if (cyc - last_we < GAP + 1) gap_viol++;
            last_we = cyc;
            last_wd = fl_wdata;
            last_wa = fl_addr;
            if (m_bk != exp_bank) bank_err++;
            if (fl_wdata == 8'hF0 && m_ofs == 0) begin
                n_rst++;
                mst <= 0;
                stuck <= 1'b0;
                busy_left <= 0;
            end else begin
                if (busy_left > 0 || stuck) early_err++;
                case (mst)
                    0: if (m_ofs == 'h555 && fl_wdata == 8'hAA) mst <= 1;
                       else begin seq_err++; mst <= 0; end
                    1: if (m_ofs == 'h2AA && fl_wdata == 8'h55) mst <= 2;
                       else begin seq_err++; mst <= 0; end
                    2: if (m_ofs == 'h555 && fl_wdata == 8'hA0) mst <= 6;
                       else if (m_ofs == 'h555 && fl_wdata == 8'h80) mst <= 3;
                       else begin seq_err++; mst <= 0; end
                    3: if (m_ofs == 'h555 && fl_wdata == 8'hAA) mst <= 4;
                       else begin seq_err++; mst <= 0; end
                    4: if (m_ofs == 'h2AA && fl_wdata == 8'h55) mst <= 5;
                       else begin seq_err++; mst <= 0; end
                    5: begin
                        if (m_ofs == 0 && fl_wdata == 8'h30) begin
                            if (!stick_erase) begin
                                for (int i = 0; i < BB; i++) mem[m_bk * BB + i] <= 8'hFF;
                            end
                            busy_left <= 3;
                            if (stick_erase) stuck <= 1'b1;
                            n_erase++;
                        end else begin
                            seq_err++;
                        end
                        mst <= 0;
                    end
                    6: begin
                        if (m_ofs != drop_ofs) mem[fl_addr] <= mem[fl_addr] & fl_wdata;
                        n_prog++;
                        busy_left <= m_ofs % 3;
                        if (m_ofs == stick_prog_ofs) stuck <= 1'b1;
                        mst <= 0;
                    end
                    default: mst <= 0;
                endcase
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input int seed);
        @(negedge clk);
        fill_seed = seed;
        fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    // mode 0: all 0xFF, 1: pattern (m,p), 2: fill seed m
    task automatic chk_bank(input int bank, input int mode, input int m, input int p,
                            input string req, input string what);
        int bad = 0;
        int first_bad = -1;
        logic [7:0] e;
        for (int i = 0; i < BB; i++) begin
            if (mode == 0) e = 8'hFF;
            else if (mode == 1) e = patt(i, m, p);
            else e = fillv(bank * BB + i, m);
            if (mem[bank * BB + i] !== e) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(bad == 0, req, what, bad, 0);
    endtask

    task automatic run_op(input bit erase, input int bank, input bit exp_tmo,
                          input bit exp_vfy, input bit inject, input string req);
        @(negedge clk);
        exp_bank = bank;
        bank_sel = BW'(bank);
        start_erase = erase;
        start_prog = !erase;
        @(negedge clk);
        start_erase = 1'b0;
        start_prog = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        chk({timeout_err, verify_err} == 2'b00, "R8", "flags cleared by start",
            {timeout_err, verify_err}, 0);
        if (inject) begin
            repeat (3) @(negedge clk);
            bank_sel = BW'(1 - bank);
            start_prog = 1'b1;
            @(negedge clk);
            start_prog = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done is one cycle", done, 0);
        chk(busy == 1'b0, "R9", "idle after done", busy, 0);
        chk(timeout_err == exp_tmo, req, "timeout flag", timeout_err, exp_tmo);
        chk(verify_err == exp_vfy, req, "verify flag", verify_err, exp_vfy);
        chk(seq_err == 0, "R1", "command sequence errors", seq_err, 0);
        chk(bank_err == 0, "R1", "writes outside selected bank", bank_err, 0);
        chk(gap_viol == 0, "R3", "write spacing violations", gap_viol, 0);
        chk(early_err == 0, "R4", "writes while device busy", early_err, 0);
        chk(last_wd == 8'hF0 && last_wa == FW'(bank * BB), "R6", "last write is reset at base",
            longint'(last_wd), 240);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles max", WDOG, WDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int e0, p0, r0, s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({busy, done, timeout_err, verify_err, fl_we, fl_re} == 6'b0, "R10",
            "outputs after reset", {busy, done, timeout_err, verify_err, fl_we, fl_re}, 0);

        do_fill(5);

        // erase bank 1 (R1, R4, R7)
        e0 = n_erase; r0 = n_rd; s0 = n_rst;
        run_op(1'b1, 1, 1'b0, 1'b0, 1'b0, "R7");
        chk(n_erase - e0 == 1, "R1", "erase commands issued", n_erase - e0, 1);
        chk(n_rd - r0 == 6 + BB, "R4", "reads in erase (3 pairs + read-back)", n_rd - r0, 6 + BB);
        chk(n_rst - s0 == 1, "R6", "reset commands", n_rst - s0, 1);
        chk_bank(1, 0, 0, 0, "R1", "bank 1 blank");
        chk_bank(0, 2, 5, 0, "R1", "bank 0 untouched by erase");

        // program bank 1 (R2, R7)
        pmul = 7; padd = 3;
        p0 = n_prog;
        run_op(1'b0, 1, 1'b0, 1'b0, 1'b0, "R7");
        chk(n_prog - p0 == BB, "R2", "bytes programmed", n_prog - p0, BB);
        chk_bank(1, 1, 7, 3, "R2", "bank 1 contents");

        // erase bank 0 with a start for bank 1 injected mid-run (R8)
        p0 = n_prog; e0 = n_erase;
        run_op(1'b1, 0, 1'b0, 1'b0, 1'b1, "R8");
        chk(n_prog - p0 == 0, "R8", "start while busy ignored (programs)", n_prog - p0, 0);
        chk(n_erase - e0 == 1, "R8", "one erase only", n_erase - e0, 1);
        chk_bank(0, 0, 0, 0, "R8", "bank 0 blank");
        chk_bank(1, 1, 7, 3, "R8", "bank 1 kept");

        // program bank 0 with another pattern (R2)
        pmul = 29; padd = 90;
        p0 = n_prog;
        run_op(1'b0, 0, 1'b0, 1'b0, 1'b0, "R2");
        chk(n_prog - p0 == BB, "R2", "bytes programmed bank 0", n_prog - p0, BB);
        chk_bank(0, 1, 29, 90, "R2", "bank 0 contents");
        chk_bank(1, 1, 7, 3, "R2", "bank 1 kept after bank 0 program");

        // erase that never completes (R5)
        do_fill(9);
        stick_erase = 1'b1;
        r0 = n_rd; s0 = n_rst;
        run_op(1'b1, 1, 1'b1, 1'b1, 1'b0, "R5");
        stick_erase = 1'b0;
        chk(n_rd - r0 == 2 * PL + 1, "R5", "reads at poll limit", n_rd - r0, 2 * PL + 1);
        chk(n_rst - s0 == 1, "R6", "reset after timeout", n_rst - s0, 1);
        repeat (6) @(negedge clk);
        chk({timeout_err, verify_err} == 2'b11, "R8", "flags hold while idle",
            {timeout_err, verify_err}, 3);

        // program stalling at offset 5 (R5)
        run_op(1'b1, 1, 1'b0, 1'b0, 1'b0, "R8");
        pmul = 3; padd = 1;
        stick_prog_ofs = 5;
        p0 = n_prog;
        run_op(1'b0, 1, 1'b1, 1'b1, 1'b0, "R5");
        stick_prog_ofs = -1;
        chk(n_prog - p0 == 6, "R5", "bytes written before stop", n_prog - p0, 6);
        chk(mem[BB + 6] == 8'hFF, "R5", "byte after stall left blank", mem[BB + 6], 255);
        chk(mem[BB + 4] == patt(4, 3, 1), "R5", "byte before stall", mem[BB + 4], patt(4, 3, 1));

        // dropped byte detected by read-back (R7)
        run_op(1'b1, 0, 1'b0, 1'b0, 1'b0, "R7");
        pmul = 11; padd = 33;
        drop_ofs = 100;
        r0 = n_rd;
        run_op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R7");
        drop_ofs = -1;
        chk(mem[100] == 8'hFF, "R7", "dropped byte still blank", mem[100], 255);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule